// File: doc/BRIEF.md
# Serial Flash Protection-Bit Write Sequencer

This block sits on the host side of a single-data-line SPI link to a serial configuration flash. It writes a new value into the flash status register, which holds the sector protection bits, and then waits until the flash has finished its self-timed internal write. A single start pulse with an 8-bit status value starts three steps. First, a write-enable command goes out in its own chip-select frame. Next comes the status-register write frame, which carries the opcode and the data byte. Last, the block polls the flag status register until the flash reports that it is ready.

The polling scheme depends on the density of the flash. A poll is a group of one, two or four flag reads, and each read sits in its own chip-select frame. The write counts as finished only when the ready bit is set in every read of one poll. When that happens, `done_o` pulses. If the polling time passes a parameterised cycle limit, `timeout_o` pulses instead. The serial clock runs in mode 0 and is divided down from the system clock.

Top module: `flash_prot_seq`

## Requirements
- R1: After reset, and at any time the block is idle, `cs_n_o` is high, `sck_o` is low, and `busy_o`, `done_o` and `timeout_o` are low.
- R2: When `start_i` is seen while the block is idle, the first chip-select frame has 8 serial clocks and carries opcode 06h, MSB first.
- R3: The second frame has 16 clocks: opcode 01h, then the captured status byte, both MSB first.
- R4: Each flag read is its own frame of 16 clocks. The block sends opcode 70h and then drives zero on `mosi_o`. It captures the flag byte MSB first on the 8 rising edges that follow the opcode.
- R5: The number of reads per poll is set by `density_i`: 00 gives 1 read, 01 gives 2 reads, and 10 or 11 gives 4 reads.
- R6: A poll succeeds only if bit 7 of the flag byte is 1 in every read of that poll. After a poll that does not succeed, and while the limit has not been reached, a new poll starts from its first read.
- R7: When a poll succeeds, `done_o` is high for exactly one cycle. `busy_o` goes low in that same cycle.
- R8: A poll may fail after polling has lasted `TIMEOUT_CYCLES` cycles. In that case `timeout_o` is high for exactly one cycle and the block goes idle. `done_o` and `timeout_o` are never high in the same operation.
- R9: `start_i` has no effect while `busy_o` is high. The status byte sent is the one captured at the accepted start, and only one completion pulse follows.
- R10: The serial link uses mode 0. `sck_o` is low whenever chip select is high. `mosi_o` changes only while `sck_o` is low. Each half period of the serial clock lasts `CLK_DIV` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised inside the block |
| start_i | input | 1 | Starts a protection write when the block is idle |
| status_i | input | 8 | Status byte to write, captured at start |
| density_i | input | 2 | Density selection that sets the reads per poll |
| busy_o | output | 1 | High while a sequence is running |
| done_o | output | 1 | One-cycle pulse on successful completion |
| timeout_o | output | 1 | One-cycle pulse when the polling limit expires |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock to the flash |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
A corrupted sequencer state shows up at the pins within one frame. A wrong read counter or a lost ready flag changes the number of flag-read frames before `done_o` rises. The scoreboard compares each chip-select frame, as it closes, against the expected opcode, data and clock count, so a bad frame is reported when it ends. An engine fault, such as a wrong bit count or wrong shift timing, corrupts the bits of the frame in progress. A broken ready-flag AND or a broken timer shows in the total number of flag reads and in which completion pulse appears.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_WR_STATUS = 8'h01;
  localparam logic [7:0] OP_RD_FLAGS  = 8'h70;
  localparam int         READY_BIT    = 7;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WREN,
    SQ_WRSR,
    SQ_POLL
  } seq_state_t;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_GAP,
    EN_SETUP,
    EN_HIGH,
    EN_LOW
  } eng_state_t;

  // density code -> flag reads per poll
  function automatic logic [2:0] reads_per_poll(input logic [1:0] dens);
    case (dens)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import flash_prot_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_i,
  input  logic [15:0] tx_i,
  input  logic        long_i,
  input  logic        miso_i,
  output logic        done_o,
  output logic [7:0]  rx_o,
  output logic        cs_n_o,
  output logic        sck_o,
  output logic        mosi_o
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  eng_state_t       st_q, st_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [15:0]      tx_q, tx_d;
  logic [4:0]       bits_q, bits_d;
  logic [7:0]       rx_q, rx_d;
  logic             cs_n_q, cs_n_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_comb begin
    st_d   = st_q;
    div_d  = (st_q == EN_IDLE || tick) ? '0 : div_q + 1'b1;
    tx_d   = tx_q;
    bits_d = bits_q;
    rx_d   = rx_q;
    cs_n_d = cs_n_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    case (st_q)
      EN_IDLE: begin
        if (go_i) begin
          st_d   = EN_GAP;
          tx_d   = tx_i;
          bits_d = long_i ? 5'd16 : 5'd8;
        end
      end
      EN_GAP: begin
        if (tick) begin
          st_d   = EN_SETUP;
          cs_n_d = 1'b0;
        end
      end
      EN_SETUP, EN_LOW: begin
        if (tick) begin
          st_d  = EN_HIGH;
          sck_d = 1'b1;
          rx_d  = {rx_q[6:0], miso_i};
        end
      end
      EN_HIGH: begin
        if (tick) begin
          sck_d = 1'b0;
          if (bits_q == 5'd1) begin
            st_d   = EN_IDLE;
            cs_n_d = 1'b1;
            done_d = 1'b1;
          end else begin
            st_d   = EN_LOW;
            tx_d   = {tx_q[14:0], 1'b0};
            bits_d = bits_q - 5'd1;
          end
        end
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      div_q  <= '0;
      tx_q   <= '0;
      bits_q <= '0;
      rx_q   <= '0;
      cs_n_q <= 1'b1;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      tx_q   <= tx_d;
      bits_q <= bits_d;
      rx_q   <= rx_d;
      cs_n_q <= cs_n_d;
      sck_q  <= sck_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign cs_n_o = cs_n_q;
  assign sck_o  = sck_q;
  assign mosi_o = tx_q[15];

  // R10: the clock only pulses inside a frame
  a_r10_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> !cs_n_q);
  // R10: data only moves while the clock is low
  a_r10_mosi_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_q[15]) |-> !sck_q);
  // R4: a finished frame leaves chip select released
  a_r4_frame_end_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cs_n_q && !sck_q);

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          expired;

  assign expired = (cnt_q >= CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)
      cnt_d = '0;
    else if (run_i && !expired)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = expired;

  // R8: the expiry flag saturates until cleared
  a_r8_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o && !clear_i |=> expired_o);

endmodule

// File: rtl/prot_seq_ctrl.sv
module prot_seq_ctrl
  import flash_prot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  status_i,
  input  logic [1:0]  density_i,
  input  logic        eng_done_i,
  input  logic [7:0]  eng_rx_i,
  input  logic        tmr_expired_i,
  output logic        eng_go_o,
  output logic [15:0] eng_tx_o,
  output logic        eng_long_o,
  output logic        tmr_clear_o,
  output logic        tmr_run_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o
);

  seq_state_t  st_q, st_d;
  logic [7:0]  status_q, status_d;
  logic [2:0]  reads_q, reads_d;
  logic [2:0]  idx_q, idx_d;
  logic        allrdy_q, allrdy_d;
  logic        go_q, go_d;
  logic [15:0] tx_q, tx_d;
  logic        long_q, long_d;
  logic        clr_q, clr_d;
  logic        done_q, done_d;
  logic        tmo_q, tmo_d;
  logic        rdy_now;
  logic        last_read;

  assign rdy_now   = allrdy_q & eng_rx_i[READY_BIT];
  assign last_read = (idx_q == reads_q - 3'd1);

  always_comb begin
    st_d     = st_q;
    status_d = status_q;
    reads_d  = reads_q;
    idx_d    = idx_q;
    allrdy_d = allrdy_q;
    go_d     = 1'b0;
    tx_d     = tx_q;
    long_d   = long_q;
    clr_d    = 1'b0;
    done_d   = 1'b0;
    tmo_d    = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          status_d = status_i;
          reads_d  = reads_per_poll(density_i);
          st_d     = SQ_WREN;
          go_d     = 1'b1;
          tx_d     = {OP_WR_ENABLE, 8'h00};
          long_d   = 1'b0;
        end
      end
      SQ_WREN: begin
        if (eng_done_i) begin
          st_d   = SQ_WRSR;
          go_d   = 1'b1;
          tx_d   = {OP_WR_STATUS, status_q};
          long_d = 1'b1;
        end
      end
      SQ_WRSR: begin
        if (eng_done_i) begin
          st_d     = SQ_POLL;
          go_d     = 1'b1;
          tx_d     = {OP_RD_FLAGS, 8'h00};
          long_d   = 1'b1;
          idx_d    = '0;
          allrdy_d = 1'b1;
          clr_d    = 1'b1;
        end
      end
      SQ_POLL: begin
        if (eng_done_i) begin
          if (last_read) begin
            if (rdy_now) begin
              st_d   = SQ_IDLE;
              done_d = 1'b1;
            end else if (tmr_expired_i) begin
              st_d  = SQ_IDLE;
              tmo_d = 1'b1;
            end else begin
              idx_d    = '0;
              allrdy_d = 1'b1;
              go_d     = 1'b1;
            end
          end else begin
            idx_d    = idx_q + 3'd1;
            allrdy_d = rdy_now;
            go_d     = 1'b1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      status_q <= '0;
      reads_q  <= 3'd1;
      idx_q    <= '0;
      allrdy_q <= 1'b1;
      go_q     <= 1'b0;
      tx_q     <= '0;
      long_q   <= 1'b0;
      clr_q    <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      status_q <= status_d;
      reads_q  <= reads_d;
      idx_q    <= idx_d;
      allrdy_q <= allrdy_d;
      go_q     <= go_d;
      tx_q     <= tx_d;
      long_q   <= long_d;
      clr_q    <= clr_d;
      done_q   <= done_d;
      tmo_q    <= tmo_d;
    end
  end

  assign eng_go_o    = go_q;
  assign eng_tx_o    = tx_q;
  assign eng_long_o  = long_q;
  assign tmr_clear_o = clr_q;
  assign tmr_run_o   = (st_q == SQ_POLL);
  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;

  // R5: reads per poll is always 1, 2 or 4
  a_r5_reads_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reads_q) == 1 && reads_q != 3'd0);
  // R6: completion follows a frame whose flag showed ready
  a_r6_done_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(eng_done_i && eng_rx_i[READY_BIT]));
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: completion and timeout are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && tmo_q));
  // R9: captured status holds through a running sequence
  a_r9_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE) |=> $stable(status_q));

endmodule

// File: rtl/flash_prot_seq.sv
module flash_prot_seq
  import flash_prot_pkg::*;
#(
  parameter int CLK_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] status_i,
  input  logic [1:0] density_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o,
  output logic       cs_n_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);

  logic [1:0]  rst_sync_q;
  logic        rst_n_int;
  logic        eng_go;
  logic [15:0] eng_tx;
  logic        eng_long;
  logic        eng_done;
  logic [7:0]  eng_rx;
  logic        tmr_clear;
  logic        tmr_run;
  logic        tmr_expired;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  prot_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .start_i       (start_i),
    .status_i      (status_i),
    .density_i     (density_i),
    .eng_done_i    (eng_done),
    .eng_rx_i      (eng_rx),
    .tmr_expired_i (tmr_expired),
    .eng_go_o      (eng_go),
    .eng_tx_o      (eng_tx),
    .eng_long_o    (eng_long),
    .tmr_clear_o   (tmr_clear),
    .tmr_run_o     (tmr_run),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o)
  );

  spi_frame_engine #(.CLK_DIV(CLK_DIV)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .go_i   (eng_go),
    .tx_i   (eng_tx),
    .long_i (eng_long),
    .miso_i (miso_i),
    .done_o (eng_done),
    .rx_o   (eng_rx),
    .cs_n_o (cs_n_o),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clear_i   (tmr_clear),
    .run_i     (tmr_run),
    .expired_o (tmr_expired)
  );

  // R1: link is quiet whenever no sequence runs
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy_o |-> cs_n_o && !sck_o);
  // R9: a sequence only begins from a start request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(busy_o) |-> $past(start_i));

endmodule

// File: tb/flash_prot_seq_tb_top.sv
`timescale 1ns/1ps
module flash_prot_seq_tb_top;

  localparam int CLK_DIV = 2;
  localparam int TMO     = 2000;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [7:0] status_i;
  logic [1:0] density_i;
  logic       busy_o, done_o, timeout_o;
  logic       cs_n_o, sck_o, mosi_o;
  logic       miso_i;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  // scoreboard: {bit count, 16-bit data}
  logic [20:0] exp_q[$];
  bit lenient = 0;

  // flash model state
  logic [15:0] fbits;
  int  fcnt = 0;
  bit  in_read = 0;
  logic [7:0] resp;
  int  busy_left = 0;
  int  rd_total = 0;

  // output monitors
  int done_cnt = 0, tmo_cnt = 0, pulse_err = 0, mosi_err = 0;
  logic prev_done = 0, prev_tmo = 0, prev_mosi = 0;

  flash_prot_seq #(.CLK_DIV(CLK_DIV), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
    .density_i(density_i), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .cs_n_o(cs_n_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model: capture host bits on rising edge
  always @(posedge sck_o) begin
    if (!cs_n_o) begin
      fbits = {fbits[14:0], mosi_o};
      fcnt++;
      if (fcnt == 8 && fbits[7:0] == 8'h70) begin
        resp = (busy_left > 0) ? 8'h01 : 8'h81;
        if (busy_left > 0) busy_left--;
        rd_total++;
        in_read = 1;
      end
    end
  end

  always @(negedge sck_o) begin
    if (!cs_n_o && in_read) begin
      miso_i <= resp[7];
      resp = {resp[6:0], 1'b0};
    end
  end

  always @(negedge cs_n_o) begin
    fbits = '0;
    fcnt = 0;
    in_read = 0;
  end

  // monitor: compare each closed frame against the scoreboard
  always @(posedge cs_n_o) begin
    logic [20:0] act;
    miso_i <= 1'b0;
    if (fcnt > 0) begin
      act = (fcnt == 8) ? {5'd8, fbits[7:0], 8'h00} : {5'(fcnt), fbits};
      if (exp_q.size() > 0) begin
        logic [20:0] e;
        e = exp_q.pop_front();
        check(act == e, (e[15:8] == 8'h06) ? "R2" : (e[15:8] == 8'h01) ? "R3" : "R4",
              "frame", act, e);
      end else if (lenient) begin
        check(act == {5'd16, 16'h7000}, "R4", "extra poll frame", act, {5'd16, 16'h7000});
      end else begin
        check(0, "R6", "unexpected frame", act, 0);
      end
    end
    fcnt = 0;
  end

  always @(negedge clk) begin
    cycles++;
    if (done_o) done_cnt++;
    if (timeout_o) tmo_cnt++;
    if ((done_o && prev_done) || (timeout_o && prev_tmo)) pulse_err++;
    if (rst_n && mosi_o !== prev_mosi && sck_o) mosi_err++;
    prev_done = done_o;
    prev_tmo  = timeout_o;
    prev_mosi = mosi_o;
  end

  // watchdog
  always @(negedge clk) begin
    if (cycles > 190000 && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int n_reads(input logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 2 : 4;
  endfunction

  task automatic run_op(input logic [7:0] st, input logic [1:0] d, input int k,
                        input bit want_tmo, input bit restart_mid);
    int n, polls, exp_reads, t0, hb;
    n = n_reads(d);
    polls = (k + n - 1) / n;
    exp_reads = n * (polls + 1);
    busy_left = k;
    rd_total = 0;
    done_cnt = 0;
    tmo_cnt = 0;
    lenient = want_tmo;
    exp_q.push_back({5'd8, 8'h06, 8'h00});
    exp_q.push_back({5'd16, 8'h01, st});
    if (!want_tmo)
      for (int i = 0; i < exp_reads; i++) exp_q.push_back({5'd16, 16'h7000});
    @(negedge clk);
    status_i  = st;
    density_i = d;
    start_i   = 1;
    @(negedge clk);
    start_i = 0;
    @(negedge clk);
    check(busy_o == 1, "R7", "busy after start", busy_o, 1);
    if (restart_mid) begin
      repeat (40) @(negedge clk);
      status_i = ~st;
      start_i  = 1;
      @(negedge clk);
      start_i = 0;
    end
    t0 = cycles;
    hb = 0;
    while (done_cnt + tmo_cnt == 0 && cycles - t0 < 60000) begin
      @(negedge clk);
      hb = busy_o;
    end
    check(busy_o == 0, "R7", "busy cleared at completion", busy_o, 0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6", "frames left in scoreboard", exp_q.size(), 0);
    if (want_tmo) begin
      check(tmo_cnt == 1 && done_cnt == 0, "R8", "timeout pulse count", tmo_cnt, 1);
      check(rd_total > 0 && rd_total % n == 0, "R8", "reads at poll boundary", rd_total, n);
      check(cycles - t0 >= TMO / 2, "R8", "timeout not early", cycles - t0, TMO / 2);
    end else begin
      check(done_cnt == 1 && tmo_cnt == 0, restart_mid ? "R9" : "R7",
            "done pulse count", done_cnt, 1);
      check(rd_total == exp_reads, "R5", "flag reads issued", rd_total, exp_reads);
    end
    check(cs_n_o == 1 && sck_o == 0, "R1", "idle link", {cs_n_o, sck_o}, 2'b10);
    exp_q.delete();
    lenient = 0;
  endtask

  initial begin
    int h0, h1;
    rst_n = 0;
    start_i = 0;
    status_i = 0;
    density_i = 0;
    miso_i = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cs_n_o == 1 && sck_o == 0, "R1", "link after reset", {cs_n_o, sck_o}, 2'b10);
    check(busy_o == 0 && done_o == 0 && timeout_o == 0, "R1", "status after reset",
          {busy_o, done_o, timeout_o}, 0);

    // R10 half-period: measure high time of sck in clk cycles
    fork
      run_op(8'h3C, 2'b00, 3, 0, 0);
      begin
        @(posedge sck_o);
        @(negedge clk);
        h0 = cycles;
        @(negedge sck_o);
        @(negedge clk);
        h1 = cycles;
        check(h1 - h0 == CLK_DIV, "R10", "sck half period", h1 - h0, CLK_DIV);
      end
    join

    run_op(8'hA5, 2'b01, 3, 0, 0);   // R5 medium, R6 partial poll
    run_op(8'h5A, 2'b10, 2, 0, 0);   // R6 ready mid-poll must re-poll
    run_op(8'hFF, 2'b11, 0, 0, 0);   // R5 code 11 -> four reads
    run_op(8'h81, 2'b10, 5, 0, 1);   // R9 restart ignored
    run_op(8'h7E, 2'b01, 100000, 1, 0); // R8 timeout

    check(pulse_err == 0, "R7", "pulse width errors", pulse_err, 0);
    check(mosi_err == 0, "R10", "mosi moved while sck high", mosi_err, 0);

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule